// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

A single timer channel built around a counter register and a data register, both `W` bits wide (16 by default). A mode input picks one of five behaviours: a periodic down-counting interval timer, a down-counting event counter, an up-counting pulse-interval capture, a retriggerable single-shot down-counter, and a single-shot high-level width measurement. Counting is paced by a one-cycle count-clock enable from an external prescaler. In event mode, counting is paced by edges on the trigger input instead.

Software starts the channel with a start strobe and halts it with a stop strobe. It can write the data register at any time. The channel reports the live count, a running flag, a one-cycle interrupt and the data register. In the capture modes, the data register holds the captured value. The trigger input is asynchronous: it is resynchronised, and its edges are classified before the controller uses them.

Top module: `mm_timer_chan`

## Requirements
- R1: During and after a synchronous active-low reset, `count_o`, `capture_o`, `running_o` and `irq_o` are all 0.
- R2: In interval mode (`mode_i` = 0, and codes 5 to 7 behave the same way), a start does not change the count. The first `cnt_tick_i` after the start loads the data register, and each later tick decrements the count.
- R3: In interval and event modes, a count step taken while the count is 0 reloads the data register and pulses `irq_o` high for exactly one cycle.
- R4: In event mode (`mode_i` = 1), the start strobe loads the data register into the counter in that same cycle. After that, each selected trigger edge decrements the count, and `cnt_tick_i` has no effect.
- R5: `edge_sel_i` = 0 selects rising edges, 1 selects falling edges, and 2 or 3 selects both. An input change is acted on at the third rising clock edge after it is applied.
- R6: In capture mode (`mode_i` = 2), the first tick after start loads 0 and later ticks increment the count. A selected edge copies the count into the data register and pulses `irq_o`, and the next tick reloads 0.
- R7: In one-count mode (`mode_i` = 3), a start given while stopped enters a waiting state. A selected edge arms the channel, and the next tick loads the data register. Ticks then decrement the count, and a step at 0 pulses `irq_o` and returns the channel to waiting. While counting, triggers and starts are ignored.
- R8: In capture-plus-one-count mode (`mode_i` = 4), a start enters the waiting state and a rising edge arms the channel. The next tick loads 0, and ticks then increment the count. A falling edge copies the count into the data register, pulses `irq_o` and returns the channel to waiting.
- R9: A stop strobe clears `running_o` and freezes the count. Stop takes priority over a start given in the same cycle.
- R10: A start given while the channel runs in interval mode restarts the sequence. The count holds until the next tick, and that tick reloads the data register.
- R11: `wr_en_i` writes `wr_data_i` into the data register, which is visible on `capture_o` in the next cycle. If a capture happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick_i | input | 1 | Count-clock enable pulse from the prescaler |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| mode_i | input | 3 | Operating mode code |
| edge_sel_i | input | 2 | Trigger edge selection |
| trig_i | input | 1 | Asynchronous trigger / event input |
| wr_en_i | input | 1 | Data register write enable |
| wr_data_i | input | W | Data register write value |
| count_o | output | W | Live counter value |
| running_o | output | 1 | Channel enabled flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| capture_o | output | W | Data register (reload or captured value) |

## Verification
The bench first targets the wait between a start and the first tick. A design that loaded at start would show the reload value one step early, and a design that counted on the first tick would be one count short. It also checks the step at zero. Reloading on the step that reaches zero, rather than on the step taken at zero, shortens every period by one and moves the interrupt.

Triggers in the wrong state are a second target. In one-count mode, an edge or a start during counting must not rearm the channel: a design that accepted it would hold the count or reload it. In event mode, a tick must not decrement the count. A falling edge must be ignored when rising edges are selected.

Capture timing is checked by the value copied into the data register and by the count freezing once the single-shot measurement ends. A missing reset to zero after a capture would keep the old count running.

// File: rtl/mmt_pkg.sv
// Shared definitions for the multi-mode timer channel.
// Assumes: mode codes above 4 are treated as interval mode by the controller.
package mmt_pkg;

    localparam logic [2:0] MODE_INTERVAL    = 3'd0;
    localparam logic [2:0] MODE_EVENT       = 3'd1;
    localparam logic [2:0] MODE_CAPTURE     = 3'd2;
    localparam logic [2:0] MODE_ONESHOT     = 3'd3;
    localparam logic [2:0] MODE_CAP_ONESHOT = 3'd4;

    localparam logic [1:0] ESEL_RISE = 2'd0;
    localparam logic [1:0] ESEL_FALL = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE,   // stopped
        ST_WAIT,   // single-shot modes: waiting for trigger
        ST_PEND,   // waiting for the first count clock
        ST_RUN     // counting
    } state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LOAD_DATA,
        CMD_LOAD_ZERO,
        CMD_DEC,
        CMD_INC,
        CMD_CAPTURE
    } cmd_e;

endpackage

// File: rtl/mmt_edge_sync.sv
// Resynchronises an asynchronous level and flags its rising and falling edges.
// Assumes: STAGES >= 2; the edge flags are single-cycle and mutually exclusive.
module mmt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the raw input through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], din_i};
    end

    // Compare the synchronised level with its previous value.
    always_comb begin
        rise_o =  chain_q[LAST-1] & ~chain_q[LAST];
        fall_o = ~chain_q[LAST-1] &  chain_q[LAST];
    end

endmodule

// File: rtl/mmt_ctrl.sv
// Mode sequencer: decides each cycle which operation the datapath performs,
// tracks the run flag and the start/wait/pending/run state, and issues the
// registered interrupt pulse.
// Assumes: the mode is not changed while the channel is running.
module mmt_ctrl
    import mmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [2:0] mode_i,
    input  logic [1:0] edge_sel_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       zero_i,
    output cmd_e       cmd_o,
    output logic       running_o,
    output logic       irq_o
);
    state_e     state_q, state_n;
    logic       run_q, run_n;
    logic       irq_q, irq_n;
    logic [2:0] mode_eff;
    logic       sel_edge;
    logic       single_shot;
    logic       zero_load;

    // Fold reserved mode codes onto interval mode.
    always_comb mode_eff = (mode_i > MODE_CAP_ONESHOT) ? MODE_INTERVAL : mode_i;

    // Pick the edge that counts as a trigger for the current selection.
    always_comb begin
        case (edge_sel_i)
            ESEL_RISE: sel_edge = rise_i;
            ESEL_FALL: sel_edge = fall_i;
            default:   sel_edge = rise_i | fall_i;
        endcase
    end

    // Classify the mode for start handling and first-load value.
    always_comb begin
        single_shot = (mode_eff == MODE_ONESHOT) || (mode_eff == MODE_CAP_ONESHOT);
        zero_load   = (mode_eff == MODE_CAPTURE) || (mode_eff == MODE_CAP_ONESHOT);
    end

    // Next-state, command and interrupt decision.
    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        irq_n   = 1'b0;
        cmd_o   = CMD_NONE;
        if (stop_i) begin
            run_n   = 1'b0;
            state_n = ST_IDLE;
        end else if (start_i && !(single_shot && run_q)) begin
            run_n = 1'b1;
            if (mode_eff == MODE_EVENT) begin
                cmd_o   = CMD_LOAD_DATA;
                state_n = ST_RUN;
            end else if (single_shot) begin
                state_n = ST_WAIT;
            end else begin
                state_n = ST_PEND;
            end
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if ((mode_eff == MODE_CAP_ONESHOT) ? rise_i : sel_edge)
                        state_n = ST_PEND;
                end
                ST_PEND: begin
                    if (tick_i) begin
                        cmd_o   = zero_load ? CMD_LOAD_ZERO : CMD_LOAD_DATA;
                        state_n = ST_RUN;
                    end
                end
                ST_RUN: begin
                    case (mode_eff)
                        MODE_EVENT: begin
                            if (sel_edge) begin
                                cmd_o = zero_i ? CMD_LOAD_DATA : CMD_DEC;
                                irq_n = zero_i;
                            end
                        end
                        MODE_CAPTURE: begin
                            if (sel_edge) begin
                                cmd_o   = CMD_CAPTURE;
                                irq_n   = 1'b1;
                                state_n = ST_PEND;
                            end else if (tick_i) begin
                                cmd_o = CMD_INC;
                            end
                        end
                        MODE_ONESHOT: begin
                            if (tick_i) begin
                                if (zero_i) begin
                                    irq_n   = 1'b1;
                                    state_n = ST_WAIT;
                                end else begin
                                    cmd_o = CMD_DEC;
                                end
                            end
                        end
                        MODE_CAP_ONESHOT: begin
                            if (fall_i) begin
                                cmd_o   = CMD_CAPTURE;
                                irq_n   = 1'b1;
                                state_n = ST_WAIT;
                            end else if (tick_i) begin
                                cmd_o = CMD_INC;
                            end
                        end
                        default: begin
                            if (tick_i) begin
                                cmd_o = zero_i ? CMD_LOAD_DATA : CMD_DEC;
                                irq_n = zero_i;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Register state, run flag and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
            irq_q   <= irq_n;
        end
    end

    assign running_o = run_q;
    assign irq_o     = irq_q;

    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !run_q);

    assert_oneshot_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MODE_ONESHOT && state_q == ST_RUN && tick_i && zero_i && !stop_i)
        |=> (state_q == ST_WAIT && irq_q));

endmodule

// File: rtl/mmt_datapath.sv
// Counter and data registers; executes one command per cycle from the
// sequencer and takes software writes to the data register.
// Assumes: a capture and a software write in the same cycle resolve to the capture.
module mmt_datapath
    import mmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cmd_e         cmd_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] data_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] data_q;

    // Update the counter according to the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (cmd_i)
                CMD_LOAD_DATA: cnt_q <= data_q;
                CMD_LOAD_ZERO: cnt_q <= '0;
                CMD_DEC:       cnt_q <= cnt_q - 1'b1;
                CMD_INC:       cnt_q <= cnt_q + 1'b1;
                default:       cnt_q <= cnt_q;
            endcase
        end
    end

    // Update the data register from a capture or a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   data_q <= '0;
        else if (cmd_i == CMD_CAPTURE) data_q <= cnt_q;
        else if (wr_en_i)              data_q <= wr_data_i;
    end

    assign cnt_o  = cnt_q;
    assign data_o = data_q;
    assign zero_o = (cnt_q == '0);

    assert_load_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_LOAD_DATA |=> cnt_q == $past(data_q));

    assert_load_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_LOAD_ZERO |=> cnt_q == '0);

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_DEC |=> cnt_q == $past(cnt_q) - 1'b1);

    assert_capture_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == CMD_CAPTURE |=> data_q == $past(cnt_q));

endmodule

// File: rtl/mm_timer_chan.sv
// Multi-mode timer channel top: trigger synchroniser, mode sequencer and
// counter/data datapath.
// Assumes: cnt_tick_i is a one-cycle enable synchronous to clk; trig_i may be asynchronous.
module mm_timer_chan #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick_i,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic [2:0]   mode_i,
    input  logic [1:0]   edge_sel_i,
    input  logic         trig_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o,
    output logic         running_o,
    output logic         irq_o,
    output logic [W-1:0] capture_o
);
    import mmt_pkg::*;

    logic rise;
    logic fall;
    logic zero;
    cmd_e cmd;

    mmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (trig_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    mmt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (cnt_tick_i),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .mode_i     (mode_i),
        .edge_sel_i (edge_sel_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .zero_i     (zero),
        .cmd_o      (cmd),
        .running_o  (running_o),
        .irq_o      (irq_o)
    );

    mmt_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cnt_o     (count_o),
        .data_o    (capture_o),
        .zero_o    (zero)
    );

    assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !start_i) |=> $stable(count_o));

endmodule

// File: tb/sim_mm_timer_chan.sv
`timescale 1ns/1ps
module sim_mm_timer_chan;
    localparam int W = 16;

    localparam logic [2:0] OP_WR    = 3'd0;
    localparam logic [2:0] OP_START = 3'd1;
    localparam logic [2:0] OP_TICK  = 3'd2;
    localparam logic [2:0] OP_STOP  = 3'd3;
    localparam logic [2:0] OP_TRIG  = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  mode;
        logic [1:0]  esel;
        logic [15:0] arg;
        logic [15:0] exp_cnt;
        logic        exp_irq;
        logic        exp_run;
    } vec_t;

    localparam int NV = 27;
    // R2 R3 R9 R10 (interval), then R4 R5 R3 (event)
    localparam vec_t VECS [NV] = '{
        '{OP_WR,    3'd0, 2'd0, 16'd3, 16'd0, 1'b0, 1'b0},
        '{OP_START, 3'd0, 2'd0, 16'd0, 16'd0, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd3, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd1, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd0, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd3, 1'b1, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b1},
        '{OP_STOP,  3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b0},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b0},
        '{OP_START, 3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd3, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b1},
        '{OP_START, 3'd0, 2'd0, 16'd0, 16'd2, 1'b0, 1'b1},
        '{OP_TICK,  3'd0, 2'd0, 16'd0, 16'd3, 1'b0, 1'b1},
        '{OP_STOP,  3'd0, 2'd0, 16'd0, 16'd3, 1'b0, 1'b0},
        '{OP_WR,    3'd1, 2'd0, 16'd5, 16'd3, 1'b0, 1'b0},
        '{OP_START, 3'd1, 2'd0, 16'd0, 16'd5, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd0, 16'd1, 16'd4, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd0, 16'd0, 16'd4, 1'b0, 1'b1},
        '{OP_TICK,  3'd1, 2'd0, 16'd0, 16'd4, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd0, 16'd1, 16'd3, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd2, 16'd0, 16'd2, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd2, 16'd1, 16'd1, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd2, 16'd0, 16'd0, 1'b0, 1'b1},
        '{OP_TRIG,  3'd1, 2'd2, 16'd1, 16'd5, 1'b1, 1'b1},
        '{OP_STOP,  3'd1, 2'd2, 16'd0, 16'd5, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick_i = 1'b0;
    logic         start_i = 1'b0;
    logic         stop_i = 1'b0;
    logic [2:0]   mode_i = 3'd0;
    logic [1:0]   edge_sel_i = 2'd0;
    logic         trig_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic [W-1:0] count_o;
    logic         running_o;
    logic         irq_o;
    logic [W-1:0] capture_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mm_timer_chan #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick_i(cnt_tick_i), .start_i(start_i),
        .stop_i(stop_i), .mode_i(mode_i), .edge_sel_i(edge_sel_i), .trig_i(trig_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .count_o(count_o),
        .running_o(running_o), .irq_o(irq_o), .capture_o(capture_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask
    task automatic pulse_stop();
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask
    task automatic pulse_tick();
        cnt_tick_i = 1'b1; @(negedge clk); cnt_tick_i = 1'b0;
    endtask
    task automatic write_data(input logic [W-1:0] v);
        wr_en_i = 1'b1; wr_data_i = v; @(negedge clk); wr_en_i = 1'b0;
    endtask
    task automatic set_trig(input logic v);
        trig_i = v; repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 run", running_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 data", capture_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            mode_i = VECS[i].mode;
            edge_sel_i = VECS[i].esel;
            case (VECS[i].op)
                OP_WR:    write_data(VECS[i].arg);
                OP_START: pulse_start();
                OP_TICK:  pulse_tick();
                OP_STOP:  pulse_stop();
                default:  set_trig(VECS[i].arg[0]);
            endcase
            chk($sformatf("R2/R3/R4/R5/R9/R10 vec%0d count", i), count_o, VECS[i].exp_cnt);
            chk($sformatf("R3 vec%0d irq", i), irq_o, VECS[i].exp_irq);
            chk($sformatf("R9 vec%0d run", i), running_o, VECS[i].exp_run);
        end

        // R6 capture mode
        mode_i = 3'd2; edge_sel_i = 2'd0;
        set_trig(1'b0);
        pulse_start();
        chk("R6 start holds", count_o, 5);
        pulse_tick();
        chk("R6 first tick zero", count_o, 0);
        repeat (3) pulse_tick();
        chk("R6 up count", count_o, 3);
        set_trig(1'b1);
        chk("R6 captured", capture_o, 3);
        chk("R6 irq", irq_o, 1);
        pulse_tick();
        chk("R6 reload zero", count_o, 0);
        pulse_tick();
        chk("R6 count again", count_o, 1);
        pulse_stop();
        write_data(16'h1234);
        chk("R11 write", capture_o, 16'h1234);

        // R7 one-count mode
        mode_i = 3'd3;
        write_data(16'd2);
        set_trig(1'b0);
        pulse_start();
        chk("R7 run flag", running_o, 1);
        pulse_tick();
        chk("R7 waiting ignores tick", count_o, 1);
        set_trig(1'b1);
        chk("R7 armed no load", count_o, 1);
        pulse_tick();
        chk("R7 load", count_o, 2);
        set_trig(1'b0);
        set_trig(1'b1);
        pulse_start();
        pulse_tick();
        chk("R7 trigger and start ignored", count_o, 1);
        pulse_tick();
        chk("R7 reach zero", count_o, 0);
        pulse_tick();
        chk("R7 irq", irq_o, 1);
        pulse_tick();
        chk("R7 back to waiting", count_o, 0);
        set_trig(1'b0);
        set_trig(1'b1);
        pulse_tick();
        chk("R7 retrigger load", count_o, 2);

        // R8 capture plus one-count
        pulse_stop();
        mode_i = 3'd4;
        set_trig(1'b0);
        pulse_start();
        pulse_tick();
        chk("R8 waiting", count_o, 2);
        set_trig(1'b1);
        pulse_tick();
        chk("R8 load zero", count_o, 0);
        repeat (4) pulse_tick();
        chk("R8 up count", count_o, 4);
        set_trig(1'b0);
        chk("R8 captured", capture_o, 4);
        chk("R8 irq", irq_o, 1);
        pulse_tick();
        chk("R8 frozen after end", count_o, 4);

        // R9 stop wins over start
        start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk("R9 stop priority", running_o, 0);

        // R1 reset mid-run
        mode_i = 3'd0;
        pulse_start();
        pulse_tick();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset count", count_o, 0);
        chk("R1 reset data", capture_o, 0);
        chk("R1 reset run", running_o, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule